// File: doc/BRIEF.md
# Mixed-Sign Indexed Dot-Product Unit

This block is the execute stage for one SIMD instruction form. It receives a 32-bit instruction word and three 128-bit vectors: a multiplicand vector, a second vector from which one 32-bit group is picked by an index in the instruction, and an accumulator vector. Each 32-bit lane of the multiplicand holds four signed bytes. Each of these bytes is multiplied by the matching unsigned byte of the picked group. The four products are summed and added into the accumulator lane.

The instruction word is checked against its fixed encoding bits and a feature-enable input. A legal operation produces the new accumulator vector and the destination register number one clock after `in_valid`, marked by `out_valid`. An illegal operation raises `out_undef` in the same cycle slot and leaves the previous result in place. A width bit in the instruction selects either four active lanes or two. In two-lane mode the upper half of the result is cleared.

Top module: `mdot_unit`

## Requirements
- R1: For each active lane e (bits 32e+31:32e), the result equals the accumulator lane plus the sum over k=0..3 of byte 4e+k of `src_a` times byte k of the selected `src_b` group.
- R2: `src_a` bytes are two's-complement signed (0x80 is -128). `src_b` bytes are unsigned (0xFF is 255).
- R3: The group index is {instr[11], instr[21]}, with instr[11] as the high bit. Index g selects bits 32g+31:32g of `src_b`, and the same group is used for every lane.
- R4: instr[30]=1 enables four lanes. instr[30]=0 enables lanes 0 and 1 only and forces result bits 127:64 to zero.
- R5: Lane accumulation wraps modulo 2^32, with no saturation.
- R6: The operation is legal only when instr[31]=0, instr[29]=0, instr[28:24]=01111, instr[23]=0, instr[22]=0, instr[15:12]=1111 and instr[10]=0. If any of these bits differs, `out_undef` rises and `out_valid` stays low.
- R7: When `feat_en` is low, every accepted operation gives `out_undef`=1 and `out_valid`=0.
- R8: Both strobes appear exactly one clock after the `in_valid` cycle. A cycle without `in_valid` is followed by a cycle with both strobes low.
- R9: `out_rd` carries instr[4:0] of the last legal operation.
- R10: After synchronous reset, `out_valid`, `out_undef`, `out_data` and `out_rd` are all zero.
- R11: An undefined operation leaves `out_data` and `out_rd` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| feat_en | input | 1 | Int8 matrix-multiply feature enabled |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | Signed-byte multiplicand vector |
| src_b | input | 128 | Unsigned-byte vector holding the indexed group |
| acc_in | input | 128 | Accumulator (destination) vector |
| out_valid | output | 1 | Legal result available |
| out_undef | output | 1 | Operation was undefined |
| out_rd | output | 5 | Destination register number |
| out_data | output | 128 | Written-back destination vector |

## Verification
The output stage has a single register, so any wrong decode or lane value appears at the ports in the cycle right after the offending `in_valid`. Some faults do not show up in every operation: a swapped index bit, a lost sign extension or a missing upper-half clear each corrupt only some lanes or index values. For this reason the sweep covers every index with both widths and with byte patterns that have the high bit set. A stuck or wrong legality term shows up as a flipped strobe pair. A write-enable leak shows up as a changed `out_data` after an undefined operation.

// File: rtl/mdot_pkg.sv
package mdot_pkg;
  localparam int LANE_W = 32;
  localparam int BYTE_W = 8;
  localparam int BYTES_PER_LANE = LANE_W / BYTE_W;

  typedef struct packed {
    logic       legal;
    logic       wide;
    logic [1:0] grp;
    logic [4:0] rd;
  } mdot_dec_t;

  // signed byte x unsigned byte, summed into a 32-bit accumulator (wraps)
  function automatic logic [LANE_W-1:0] lane_dot(
    input logic [LANE_W-1:0] acc,
    input logic [LANE_W-1:0] sw,
    input logic [LANE_W-1:0] uw
  );
    logic [LANE_W-1:0] sum;
    logic signed [16:0] sa, ub, p;
    sum = acc;
    for (int k = 0; k < BYTES_PER_LANE; k++) begin
      sa  = {{9{sw[BYTE_W*k+BYTE_W-1]}}, sw[BYTE_W*k +: BYTE_W]};
      ub  = {9'b0, uw[BYTE_W*k +: BYTE_W]};
      p   = sa * ub;
      sum = sum + {{15{p[16]}}, p};
    end
    return sum;
  endfunction
endpackage

// File: rtl/mdot_decode.sv
module mdot_decode
  import mdot_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        feat_en,
  output mdot_dec_t   dec,
  output logic        fixed_ok
);
  logic unused_fields;
  assign unused_fields = ^{instr[20:16], instr[9:5]};

  always_comb begin
    fixed_ok = (instr[31] == 1'b0) &&
               (instr[29] == 1'b0) &&
               (instr[28:24] == 5'b01111) &&
               (instr[23] == 1'b0) &&
               (instr[22] == 1'b0) &&
               (instr[15:12] == 4'b1111) &&
               (instr[10] == 1'b0);
    dec.legal = fixed_ok && feat_en;
    dec.wide  = instr[30];
    dec.grp   = {instr[11], instr[21]};
    dec.rd    = instr[4:0];
  end
endmodule

// File: rtl/mdot_lane.sv
module mdot_lane
  import mdot_pkg::*;
(
  input  logic              active,
  input  logic [LANE_W-1:0] acc,
  input  logic [LANE_W-1:0] sw,
  input  logic [LANE_W-1:0] uw,
  output logic [LANE_W-1:0] res
);
  always_comb res = active ? lane_dot(acc, sw, uw) : '0;
endmodule

// File: rtl/mdot_unit.sv
module mdot_unit
  import mdot_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             feat_en,
  input  logic [31:0]      instr,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic [VEC_W-1:0] acc_in,
  output logic             out_valid,
  output logic             out_undef,
  output logic [4:0]       out_rd,
  output logic [VEC_W-1:0] out_data
);
  localparam int NUM_LANES = VEC_W / LANE_W;
  localparam int NARROW_LANES = NUM_LANES / 2;

  mdot_dec_t         dec;
  logic              fixed_ok;
  logic [LANE_W-1:0] grp_word;
  logic [VEC_W-1:0]  next_data;
  logic              accept_w;
  logic              reject_w;

  mdot_decode u_dec (
    .instr    (instr),
    .feat_en  (feat_en),
    .dec      (dec),
    .fixed_ok (fixed_ok)
  );

  assign grp_word = src_b[dec.grp*LANE_W +: LANE_W];
  assign accept_w = in_valid && dec.legal;
  assign reject_w = in_valid && !dec.legal;

  for (genvar e = 0; e < NUM_LANES; e++) begin : g_lane
    logic act;
    if (e < NARROW_LANES) begin : g_lo
      assign act = 1'b1;
    end else begin : g_hi
      assign act = dec.wide;
    end
    mdot_lane u_lane (
      .active (act),
      .acc    (acc_in[e*LANE_W +: LANE_W]),
      .sw     (src_a[e*LANE_W +: LANE_W]),
      .uw     (grp_word),
      .res    (next_data[e*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_undef <= 1'b0;
      out_rd    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= accept_w;
      out_undef <= reject_w;
      if (accept_w) begin
        out_rd   <= dec.rd;
        out_data <= next_data;
      end
    end
  end

  // R8
  accept_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fixed_ok && feat_en) |=> (out_valid && !out_undef));

  // R7
  feat_off_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !feat_en) |=> (out_undef && !out_valid));

  // R8
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_undef));

  // R4
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(instr[30])) |-> (out_data[VEC_W-1:VEC_W/2] == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> ($stable(out_data) && $stable(out_rd)));
endmodule

// File: tb/mdot_unit_test.sv
`timescale 1ns/1ps
module mdot_unit_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         feat_en;
  logic [31:0]  instr;
  logic [127:0] src_a, src_b, acc_in;
  logic         out_valid, out_undef;
  logic [4:0]   out_rd;
  logic [127:0] out_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mdot_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .feat_en(feat_en),
    .instr(instr), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .out_undef(out_undef), .out_rd(out_rd),
    .out_data(out_data)
  );

  function automatic logic [31:0] mk(bit q, bit h, bit l, logic [4:0] rd);
    return {1'b0, q, 1'b0, 5'b01111, 1'b0, 1'b0, l, 1'b1, 4'h5,
            4'hF, h, 1'b0, 5'd9, rd};
  endfunction

  function automatic logic [127:0] model(logic [31:0] ins, logic [127:0] a,
                                         logic [127:0] b, logic [127:0] c);
    logic [127:0] r = '0;
    int g = ins[11] * 2 + ins[21];
    int n = ins[30] ? 4 : 2;
    for (int e = 0; e < n; e++) begin
      int s = int'(c[32*e +: 32]);
      for (int k = 0; k < 4; k++) begin
        int av = int'($signed(a[8*(4*e+k) +: 8]));
        int bv = int'({24'b0, b[8*(4*g+k) +: 8]});
        s = s + av * bv;
      end
      r[32*e +: 32] = s;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] ins, logic [127:0] a, logic [127:0] b,
                       logic [127:0] c, bit fe);
    @(negedge clk);
    in_valid = 1'b1; feat_en = fe; instr = ins;
    src_a = a; src_b = b; acc_in = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, c, last_d;
    logic [31:0]  ins;
    int fixed_pos[14] = '{31, 29, 28, 27, 26, 25, 24, 23, 22, 15, 14, 13, 12, 10};
    rst = 1'b1; in_valid = 1'b0; feat_en = 1'b1; instr = '0;
    src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 valid", {127'b0, out_valid}, 128'd0);
    chk("R10 undef", {127'b0, out_undef}, 128'd0);
    chk("R10 rd", {123'b0, out_rd}, 128'd0);
    chk("R10 data", out_data, 128'd0);

    // R1 R3 R4 R9 sweep: both widths, every index, random patterns
    for (int q = 0; q < 2; q++)
      for (int g = 0; g < 4; g++)
        for (int p = 0; p < 8; p++) begin
          a = {$urandom, $urandom, $urandom, $urandom};
          b = {$urandom, $urandom, $urandom, $urandom};
          c = {$urandom, $urandom, $urandom, $urandom};
          ins = mk(q[0], g[1], g[0], 5'(p * 3 + g));
          issue(ins, a, b, c, 1'b1);
          chk("R1 R3 R4 data", out_data, model(ins, a, b, c));
          chk("R8 valid", {126'b0, out_valid, out_undef}, 128'd2);
          chk("R9 rd", {123'b0, out_rd}, {123'b0, ins[4:0]});
        end

    // R2 signedness: -128 * 255 four times
    a = {16{8'h80}}; b = {16{8'hFF}}; c = '0;
    issue(mk(1'b1, 1'b0, 1'b1, 5'd1), a, b, c, 1'b1);
    chk("R2 signed x unsigned", out_data, {4{32'hFFFE0200}});

    // R3 distinct groups: group 2 = bytes of 3, a = 1s
    a = {16{8'h01}}; b = {32'h04040404, 32'h03030303, 32'h02020202, 32'h01010101};
    issue(mk(1'b1, 1'b1, 1'b0, 5'd2), a, b, '0, 1'b1);
    chk("R3 index H high", out_data, {4{32'd12}});

    // R5 wrap
    c = {4{32'h7FFFFFFF}};
    issue(mk(1'b1, 1'b0, 1'b0, 5'd3), {16{8'h01}}, {16{8'h01}}, c, 1'b1);
    chk("R5 wrap", out_data, {4{32'h80000003}});
    c = {4{32'hFFFFFFFF}};
    issue(mk(1'b0, 1'b0, 1'b0, 5'd4), {16{8'h01}}, {16{8'h01}}, c, 1'b1);
    chk("R5 wrap narrow R4", out_data, {64'd0, {2{32'h00000003}}});
    last_d = out_data;

    // R6 each fixed bit flipped
    foreach (fixed_pos[i]) begin
      ins = mk(1'b1, 1'b0, 1'b0, 5'd30);
      ins[fixed_pos[i]] = ~ins[fixed_pos[i]];
      issue(ins, {$urandom, $urandom, $urandom, $urandom}, b, c, 1'b1);
      chk("R6 strobes", {126'b0, out_valid, out_undef}, 128'd1);
      chk("R11 data held", out_data, last_d);
      chk("R11 rd held", {123'b0, out_rd}, 128'd4);
    end

    // R7 feature disabled
    issue(mk(1'b1, 1'b1, 1'b1, 5'd17), a, b, c, 1'b0);
    chk("R7 strobes", {126'b0, out_valid, out_undef}, 128'd1);
    chk("R11 data held", out_data, last_d);

    // R8 idle cycle
    @(negedge clk);
    chk("R8 idle", {126'b0, out_valid, out_undef}, 128'd0);

    // R8 back to back
    a = {16{8'hFE}}; b = {16{8'h10}};
    @(negedge clk);
    in_valid = 1'b1; feat_en = 1'b1; instr = mk(1'b1, 1'b0, 1'b0, 5'd5);
    src_a = a; src_b = b; acc_in = '0;
    @(negedge clk);
    chk("R8 b2b first", out_data, model(mk(1'b1, 1'b0, 1'b0, 5'd5), a, b, '0));
    instr = mk(1'b0, 1'b1, 1'b1, 5'd6); acc_in = {4{32'd100}};
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 b2b second", out_data, model(mk(1'b0, 1'b1, 1'b1, 5'd6), a, b, {4{32'd100}}));
    chk("R9 b2b rd", {123'b0, out_rd}, 128'd6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule